// File: doc/BRIEF.md
# Byte-Addressed Register Target on a Two-Wire Serial Bus

This block is an I2C target. It gives a bus master access to a byte-addressed register space. That space holds a 64-byte user memory at the bottom of the address map and a 16-byte control window at the top. SCL and SDA arrive as plain digital inputs and are synchronised inside the block. The block never drives SDA high. It only requests a low level through `sda_drive_low`, which the pad logic turns into an open-drain pull-down. Clock stretching and 10-bit addressing are not used.

The target answers to a 7-bit address. Its upper six bits are fixed by parameter and its lowest bit comes from the `addr_strap` input. After the address byte, a write transfer carries one byte that loads the internal address pointer, followed by up to eight data bytes. The pointer advances inside its 8-byte aligned page after each stored byte. A read transfer first sets the pointer with a write that carries no data. A repeated START with the read bit set follows. Bytes then stream out from linearly increasing addresses for as long as the master acknowledges them.

The register space sits behind a small parallel port:
- `reg_we` pulses for one cycle, with `reg_addr` and `reg_wdata` valid in that cycle.
- `reg_re` pulses for one cycle, and `reg_rdata` must be valid in that same cycle.

An address outside both windows is refused on write and reads back as 00h, whatever `reg_rdata` holds.

Top module: `i2c_regslave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 1010_00 followed by the `addr_strap` level. Any other address gets no acknowledge and causes no strobe.
- R2: Every received and transmitted byte moves most significant bit first.
- R3: In a write transfer, the byte after the address is always acknowledged and loads the pointer. Each following in-range data byte is acknowledged and produces exactly one `reg_we` pulse carrying the pointer and that byte.
- R4: After each stored write byte, the pointer advances within its 8-byte aligned page: bits 2:0 wrap from 7 to 0 and bits 7:3 stay unchanged.
- R5: A pointer-setting write, then a repeated START with the read bit set, returns the byte at the pointer. It is fetched by one `reg_re` pulse at that address.
- R6: While the master acknowledges read bytes, the pointer advances by one across page boundaries. A master NACK ends the transfer with SDA released.
- R7: Data bytes aimed at addresses 40h to EFh are not acknowledged and produce no `reg_we`. Reads from those addresses return 00h.
- R8: `sda_drive_low` is only ever asserted while the synchronised SCL is low.
- R9: `reg_we` and `reg_re` are single-cycle pulses and are never high together.
- R10: With a 50 MHz system clock, transfers work at both 100 kbit/s and 400 kbit/s.
- R11: During reset and right after it, `sda_drive_low`, `reg_we` and `reg_re` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock level as seen at the pad |
| sda_in | input | 1 | Bus data level as seen at the pad |
| addr_strap | input | 1 | Board strap giving the lowest target address bit |
| sda_drive_low | output | 1 | Request to pull SDA low |
| reg_addr | output | 8 | Register address (current pointer) |
| reg_wdata | output | 8 | Write data, valid while `reg_we` is high |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, sampled in the cycle `reg_re` is high |

## Verification
Faults in the internal state show up at the ports in different ways:
- A wrong bit count or a misaligned shift register corrupts the `reg_wdata` or `reg_addr` seen on the very next write strobe. The bench compares every strobe, clock by clock, against a queue of predicted writes.
- A pointer that breaks its page wrap, or that fails to step linearly on reads, shows up in the same transfer. Either a strobe lands at the wrong address or the next byte read back differs from the model memory.
- A stuck protocol state shows up within one byte time. Either an acknowledge bit is missing or unexpected, or `sda_drive_low` stays asserted after STOP.

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
  parameter logic [5:0] DEV_CODE   = 6'b101000,
  parameter int         MEM_BYTES  = 64,
  parameter int         CTRL_BASE  = 240,
  parameter int         CTRL_BYTES = 16,
  parameter int         PAGE_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       addr_strap,
  output logic       sda_drive_low,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  output logic       reg_re,
  input  logic [7:0] reg_rdata
);
  localparam int         PG_W    = $clog2(PAGE_BYTES);
  localparam logic [7:0] MEM_END = 8'(MEM_BYTES - 1);
  localparam logic [7:0] CTRL_LO = 8'(CTRL_BASE);
  localparam logic [7:0] CTRL_HI = 8'(CTRL_BASE + CTRL_BYTES - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_MADR, S_MADR_ACK, S_WR, S_WR_ACK, S_RD, S_RD_ACK
  } st_t;

  st_t        state;
  logic [1:0] scl_sy, sda_sy;
  logic       scl_p, sda_p;
  logic [3:0] cnt;
  logic [7:0] sh, tx, ptr;
  logic       rw, oe, wr_go, rd_go;

  wire scl_q    = scl_sy[1];
  wire sda_q    = sda_sy[1];
  wire scl_rise = scl_q & ~scl_p;
  wire scl_fall = ~scl_q & scl_p;
  wire start_c  = scl_q & scl_p & sda_p & ~sda_q;
  wire stop_c   = scl_q & scl_p & ~sda_p & sda_q;
  wire ok       = (ptr <= MEM_END) || (ptr >= CTRL_LO && ptr <= CTRL_HI);
  wire [7:0] pg_next = {ptr[7:PG_W], ptr[PG_W-1:0] + 1'b1};

  assign sda_drive_low = oe;
  assign reg_addr      = ptr;
  assign reg_wdata     = sh;
  assign reg_we        = wr_go;
  assign reg_re        = rd_go;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_p  <= scl_q;
      sda_p  <= sda_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0; ptr <= '0;
      rw <= 1'b0; oe <= 1'b0; wr_go <= 1'b0; rd_go <= 1'b0;
    end else begin
      wr_go <= 1'b0;
      rd_go <= 1'b0;
      if (wr_go) ptr <= pg_next;
      if (rd_go) tx <= ok ? reg_rdata : 8'h00;
      if (start_c) begin
        state <= S_DEV; cnt <= '0; oe <= 1'b0;
      end else if (stop_c) begin
        state <= S_IDLE; oe <= 1'b0;
      end else begin
        case (state)
          S_DEV, S_MADR, S_WR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_q};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              case (state)
                S_DEV:
                  if (sh[7:1] == {DEV_CODE, addr_strap}) begin
                    oe <= 1'b1; rw <= sh[0]; rd_go <= sh[0]; state <= S_DEV_ACK;
                  end else begin
                    state <= S_IDLE;
                  end
                S_MADR: begin
                  oe <= 1'b1; ptr <= sh; state <= S_MADR_ACK;
                end
                default: begin
                  oe <= ok; wr_go <= ok; state <= S_WR_ACK;
                end
              endcase
            end
          end
          S_DEV_ACK, S_MADR_ACK, S_WR_ACK:
            if (scl_fall) begin
              if (state == S_DEV_ACK && rw) begin
                oe <= ~tx[7]; tx <= {tx[6:0], 1'b0}; cnt <= 4'd1; state <= S_RD;
              end else begin
                oe <= 1'b0; cnt <= '0;
                state <= (state == S_DEV_ACK) ? S_MADR : S_WR;
              end
            end
          S_RD:
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                oe <= 1'b0; cnt <= '0; state <= S_RD_ACK;
              end else begin
                oe <= ~tx[7]; tx <= {tx[6:0], 1'b0}; cnt <= cnt + 1'b1;
              end
            end
          S_RD_ACK:
            if (scl_rise) begin
              if (sda_q) state <= S_IDLE;
              else begin
                ptr <= ptr + 1'b1; rd_go <= 1'b1;
              end
            end else if (scl_fall) begin
              oe <= ~tx[7]; tx <= {tx[6:0], 1'b0}; cnt <= 4'd1; state <= S_RD;
            end
          default: ;
        endcase
      end
    end

  assert_oe_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> !scl_q);
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_go && rd_go));
  assert_we_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> !wr_go);
  assert_we_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> ok);
  assert_page_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> ptr[7:PG_W] == $past(ptr[7:PG_W]));
  assert_re_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |-> (state == S_DEV_ACK || state == S_RD_ACK));
endmodule

// File: tb/tb_i2c_regslave.sv
`timescale 1ns/1ps
module tb_i2c_regslave;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, scl_m, sda_m, strap;
  logic sda_oe, reg_we, reg_re;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  wire sda_line = sda_m & ~sda_oe;

  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  logic [7:0] wbuf [8];
  logic [15:0] exp_q [$];
  logic [15:0] e_w;
  int total = 0, bad = 0, hp = 1250;
  bit done = 0;

  i2c_regslave dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .addr_strap(strap),
    .sda_drive_low(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata));

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  task automatic chk(input bit c, input string req, input int act, input int exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit in_rng(input logic [7:0] a);
    return (a < 8'h40) || (a >= 8'hF0);
  endfunction

  always @(negedge clk) if (rst_n) begin
    if (reg_we) begin
      if (exp_q.size() == 0) chk(0, "R3 unexpected write strobe", reg_addr, 0);
      else begin
        e_w = exp_q.pop_front();
        chk({reg_addr, reg_wdata} == e_w, "R3 R4 R2 write strobe addr,data",
            {reg_addr, reg_wdata}, e_w);
      end
    end
    if (reg_we && reg_re) chk(0, "R9 strobes together", 1, 0);
  end

  task automatic i2c_start;
    #(hp/2) sda_m = 1'b1;
    #(hp/2) scl_m = 1'b1;
    #hp sda_m = 1'b0;
    #hp scl_m = 1'b0;
  endtask

  task automatic i2c_stop;
    #(hp/2) sda_m = 1'b0;
    #(hp/2) scl_m = 1'b1;
    #hp sda_m = 1'b1;
    #hp;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      #(hp/2) sda_m = b[i];
      #(hp/2) scl_m = 1'b1;
      #hp scl_m = 1'b0;
    end
    #(hp/2) sda_m = 1'b1;
    #(hp/2) scl_m = 1'b1;
    #(hp/2) acked = !sda_line;
    #(hp/2) scl_m = 1'b0;
  endtask

  task automatic read_byte(input bit last, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      #hp scl_m = 1'b1;
      #(hp/2) b = {b[6:0], sda_line};
      #(hp/2) scl_m = 1'b0;
    end
    #(hp/2) sda_m = last;
    #(hp/2) scl_m = 1'b1;
    #hp scl_m = 1'b0;
    #(hp/2) sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] dev, input logic [7:0] a, input int n,
                          input bit dev_ok);
    bit ak, ea;
    logic [7:0] p;
    p = a;
    i2c_start;
    send_byte(dev, ak);
    chk(ak == dev_ok, "R1 device address acknowledge", ak, dev_ok);
    if (ak) begin
      send_byte(a, ak);
      chk(ak, "R3 pointer byte acknowledge", ak, 1);
      for (int k = 0; k < n; k++) begin
        ea = in_rng(p);
        if (ea) begin
          exp_q.push_back({p, wbuf[k]});
          ref_mem[p] = wbuf[k];
        end
        send_byte(wbuf[k], ak);
        chk(ak == ea, ea ? "R3 data acknowledge" : "R7 out-of-range data refused", ak, ea);
        if (ea) p = {p[7:3], p[2:0] + 3'd1};
      end
    end
    i2c_stop;
    #200;
    chk(exp_q.size() == 0, "R3 every predicted write strobe seen", exp_q.size(), 0);
    chk(sda_oe == 1'b0, "R8 SDA released after STOP", sda_oe, 0);
  endtask

  task automatic do_read(input logic [7:0] dev, input logic [7:0] a, input int n);
    bit ak;
    logic [7:0] p, b, ev;
    p = a;
    i2c_start;
    send_byte(dev, ak);
    chk(ak, "R5 device acknowledge for pointer write", ak, 1);
    send_byte(a, ak);
    chk(ak, "R5 pointer byte acknowledge", ak, 1);
    i2c_start;
    send_byte(dev | 8'h01, ak);
    chk(ak, "R5 read address acknowledge after repeated START", ak, 1);
    for (int k = 0; k < n; k++) begin
      read_byte(k == n - 1, b);
      ev = in_rng(p) ? ref_mem[p] : 8'h00;
      chk(b == ev, k == 0 ? "R5 first read byte" :
          (in_rng(p) ? "R6 sequential read byte" : "R7 out-of-range read is 00"), b, ev);
      p = p + 8'd1;
    end
    i2c_stop;
    #200;
    chk(sda_oe == 1'b0, "R6 SDA released after NACK and STOP", sda_oe, 0);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    scl_m = 1'b1; sda_m = 1'b1; strap = 1'b0; rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #5;
    chk({sda_oe, reg_we, reg_re} == 3'b000, "R11 outputs low in reset", {sda_oe, reg_we, reg_re}, 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #5;
    chk({sda_oe, reg_we, reg_re} == 3'b000, "R11 outputs low after reset", {sda_oe, reg_we, reg_re}, 0);

    // R1: wrong strap bit in address
    wbuf[0] = 8'h99;
    do_write(8'hA2, 8'h05, 1, 0);

    // R10: slow bus rate, single write and readback
    hp = 5000;
    wbuf[0] = 8'h3C;
    do_write(8'hA0, 8'h05, 1, 1);
    do_read(8'hA0, 8'h05, 1);
    hp = 1250;

    // R4: page write wraps 0F -> 08
    wbuf[0] = 8'hC1; wbuf[1] = 8'h52; wbuf[2] = 8'hE7; wbuf[3] = 8'h0D;
    do_write(8'hA0, 8'h0E, 4, 1);
    // R6: linear read across the page edge
    do_read(8'hA0, 8'h0E, 4);
    do_read(8'hA0, 8'h08, 2);

    // R7: out-of-range write and read
    wbuf[0] = 8'h11;
    do_write(8'hA0, 8'h80, 1, 1);
    do_read(8'hA0, 8'h80, 1);
    do_read(8'hA0, 8'h3E, 3);

    // control window
    wbuf[0] = 8'hA5;
    do_write(8'hA0, 8'hF4, 1, 1);
    do_read(8'hA0, 8'hF4, 1);

    // R1: strap high selects the other address
    strap = 1'b1;
    wbuf[0] = 8'h77;
    do_write(8'hA0, 8'h20, 1, 0);
    do_write(8'hA2, 8'h20, 1, 1);
    do_read(8'hA2, 8'h20, 1);

    done = 1;
    finish_run;
  end
endmodule